// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder

This block is a synthesizable model of a small serial EEPROM holding 16-bit words, for use as the target device when verifying or emulating a host that speaks the select/clock/data-in/data-out protocol. It samples chip select, the serial clock and data-in on the system clock. It treats a low-to-high step of the serial clock as one bit time, decodes each instruction from the incoming stream, and drives data-out. The storage is an internal register array of `2**AW` words. `AW` is 6 for the small variant and 8 for the large one.

An instruction opens with a 1 bit. A two-bit operation code follows, then `AW` address bits MSB first. Writes then take 16 data bits MSB first. Operation code 00 is an extended group: the two upper address bits choose among unlocking, locking, clearing every word and filling every word, and the lower address bits are ignored. A sticky write-enable latch, which unlocking sets and locking clears, gates every change to the storage. Dropping chip select abandons whatever is in flight.

The controller has six states:
- IDLE waits for a start bit.
- OPC collects the operation code.
- ADDR collects the address and decodes the command.
- DATA collects a write word.
- READ streams a word out.
- DONE ignores further clocks until select drops.

Transitions:
- IDLE→OPC on a 1 bit.
- OPC→ADDR after two bits.
- ADDR→READ for a read.
- ADDR→DATA for a write or a fill.
- ADDR→DONE for erase, unlock, lock and clear.
- DATA→DONE after 16 bits.
- READ→DONE after 17 edges.
- Any state goes to IDLE while select is low.

Top module: `mw_eeprom`

## Requirements
- R1: While select is high and the controller is idle, clock edges with data-in 0 are ignored. The first edge with data-in 1 is the start bit, and a command then shifted in completes normally.
- R2: Operation code 10 reads the addressed word. Data-out is 0 from the edge that takes the last address bit. The next 16 rising edges each present one bit, bit 15 first and bit 0 last. The 17th edge returns data-out to 0.
- R3: Operation code 01 takes 16 data bits, MSB first, after the address. It stores them at the address when the write-enable latch is set.
- R4: Operation code 11 sets the addressed word to 16'hFFFF when the write-enable latch is set.
- R5: Operation code 00 with address bits [AW-1:AW-2] = 11 sets the write-enable latch, and with 00 clears it. The remaining address bits have no effect.
- R6: Operation code 00 with upper address bits 10 sets every word to 16'hFFFF. With upper bits 01 it takes 16 data bits and writes them to every word. Both need the latch set.
- R7: While the write-enable latch is clear, write, erase, clear-all and fill-all leave every word unchanged.
- R8: Select low at any point abandons the current command without effect. The next command needs a new start bit.
- R9: Data-out is 0 whenever no read word is being shifted out.
- R10: After reset every word reads 16'hFFFF and the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; a rising step advances one bit |
| di | input | 1 | Serial data into the device |
| dout | output | 1 | Serial data out of the device |

## Verification
The assertions assume that the serial lines are synchronous to `clk`. They also assume that each level of `sk` lasts at least one system clock, and that `di` and `cs` are steady when `sk` rises. The bench therefore changes every line only on the falling edge of `clk`. It holds each `sk` level for two system clocks and moves `di` only while `sk` is low. It drops `cs` only after `sk` has returned low, except in the abort cases, which deliberately cut a command short.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_e;

    typedef enum logic [1:0] {
        EXT_LOCK   = 2'b00,
        EXT_FILL   = 2'b01,
        EXT_CLEAR  = 2'b10,
        EXT_UNLOCK = 2'b11
    } mw_ext_e;

endpackage

// File: rtl/mw_sk_edge.sv
module mw_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk_in,
    output logic rise
);

    logic sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk_in;
    end

    assign rise = sk_in & ~sk_q;

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          fill,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '1;
            else if (fill || (we && addr == AW'(i)))
                word_q <= wdata;
        end
        assign words[i] = word_q;
    end

    assign rdata = words[addr];

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we, fill})); // R6

endmodule

// File: rtl/mw_rd_shifter.sv
module mw_rd_shifter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic          clear,
    input  logic [DW-1:0] word,
    output logic          dout
);

    logic [DW:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else if (clear)
            sh_q <= '0;
        else if (load)
            sh_q <= {1'b0, word};
        else if (shift)
            sh_q <= {sh_q[DW-1:0], 1'b0};
    end

    assign dout = sh_q[DW];

    AST_DOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(load) || $past(shift) || $past(clear))); // R2

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = WORD_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout
);

    localparam int CW = $clog2(DW + 1);

    mw_state_e     st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [1:0]    opc_q, opc_n;
    logic [AW-1:0] adr_q, adr_n;
    logic [DW-1:0] dat_q, dat_n;
    logic          wen_q, wen_n;

    logic          sk_rise;
    logic          mem_we, mem_fill, rd_load, rd_shift, rd_clear;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [AW-1:0] adr_shift;
    logic [DW-1:0] dat_shift;
    logic [1:0]    sub_op;

    assign adr_shift = {adr_q[AW-2:0], di};
    assign dat_shift = {dat_q[DW-2:0], di};
    assign sub_op    = adr_shift[AW-1 -: 2];

    mw_sk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sk_in (sk),
        .rise  (sk_rise)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            opc_q <= '0;
            adr_q <= '0;
            dat_q <= '0;
            wen_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            opc_q <= opc_n;
            adr_q <= adr_n;
            dat_q <= dat_n;
            wen_q <= wen_n;
        end
    end

    // Next state and strobes
    always_comb begin
        st_n      = st_q;
        cnt_n     = cnt_q;
        opc_n     = opc_q;
        adr_n     = adr_q;
        dat_n     = dat_q;
        wen_n     = wen_q;
        mem_we    = 1'b0;
        mem_fill  = 1'b0;
        mem_wdata = '1;
        rd_load   = 1'b0;
        rd_shift  = 1'b0;
        rd_clear  = 1'b0;
        if (!cs) begin
            st_n     = ST_IDLE;
            cnt_n    = '0;
            rd_clear = 1'b1;
        end else if (sk_rise) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (di) begin
                        st_n  = ST_OPC;
                        cnt_n = '0;
                    end
                end
                ST_OPC: begin
                    opc_n = {opc_q[0], di};
                    if (cnt_q == CW'(1)) begin
                        st_n  = ST_ADDR;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_ADDR: begin
                    adr_n = adr_shift;
                    if (cnt_q == CW'(AW - 1)) begin
                        cnt_n = '0;
                        case (opc_q)
                            OP_READ: begin
                                rd_load = 1'b1;
                                st_n    = ST_READ;
                            end
                            OP_WRITE: st_n = ST_DATA;
                            OP_ERASE: begin
                                mem_we = wen_q;
                                st_n   = ST_DONE;
                            end
                            default: begin
                                case (sub_op)
                                    EXT_UNLOCK: begin
                                        wen_n = 1'b1;
                                        st_n  = ST_DONE;
                                    end
                                    EXT_LOCK: begin
                                        wen_n = 1'b0;
                                        st_n  = ST_DONE;
                                    end
                                    EXT_CLEAR: begin
                                        mem_fill = wen_q;
                                        st_n     = ST_DONE;
                                    end
                                    default: st_n = ST_DATA;
                                endcase
                            end
                        endcase
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    dat_n = dat_shift;
                    if (cnt_q == CW'(DW - 1)) begin
                        cnt_n     = '0;
                        mem_wdata = dat_shift;
                        if (opc_q == OP_EXT) mem_fill = wen_q;
                        else                 mem_we   = wen_q;
                        st_n = ST_DONE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_READ: begin
                    rd_shift = 1'b1;
                    if (cnt_q == CW'(DW)) begin
                        cnt_n = '0;
                        st_n  = ST_DONE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    mw_word_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .fill  (mem_fill),
        .addr  (adr_n),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    mw_rd_shifter #(.DW(DW)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load),
        .shift (rd_shift),
        .clear (rd_clear),
        .word  (mem_rdata),
        .dout  (dout)
    );

    AST_IDLE_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cs && sk_rise && !di) |=> (st_q == ST_IDLE)); // R1
    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (st_q == ST_IDLE)); // R8
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_READ) |-> !dout); // R9
    AST_WEN_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wen_q) |-> $past(st_q == ST_ADDR && opc_q == OP_EXT && cs && sk_rise)); // R5
    AST_WEN_CLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wen_q) |-> $past(st_q == ST_ADDR && opc_q == OP_EXT && cs && sk_rise)); // R5
    AST_PROG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_fill) |-> wen_q); // R7

endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DW-1:0] mdl [DEPTH];
    bit            wen_m;

    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] got_q [$];
    string         tag_q [$];

    always #4 clk = ~clk;

    mw_eeprom #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        di = b; sk = 1'b0; tick(2);
        sk = 1'b1; tick(2);
    endtask

    task automatic cs_end();
        sk = 1'b0; tick(2);
        cs = 1'b0; di = 1'b0; tick(2);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
        cs = 1'b1;
        bit_out(1'b1);
        for (int i = 1; i >= 0; i--) bit_out(op[i]);
        for (int i = AW - 1; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic send_word(input logic [DW-1:0] w);
        for (int i = DW - 1; i >= 0; i--) bit_out(w[i]);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] w;
        exp_q.push_back(mdl[a]);
        tag_q.push_back(req);
        cmd(2'b10, a);
        check(dout == 1'b0, "R2 dummy bit", DW'(dout), '0);
        w = '0;
        for (int i = 0; i < DW; i++) begin
            bit_out(1'b0);
            w = {w[DW-2:0], dout};
        end
        got_q.push_back(w);
        bit_out(1'b0);
        check(dout == 1'b0, "R2 after word", DW'(dout), '0);
        cs_end();
        check(dout == 1'b0, "R9 deselected", DW'(dout), '0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd(2'b01, a); send_word(d); cs_end();
        if (wen_m) mdl[a] = d;
    endtask

    task automatic erase(input logic [AW-1:0] a);
        cmd(2'b11, a); cs_end();
        if (wen_m) mdl[a] = '1;
    endtask

    task automatic ext(input logic [1:0] sub, input logic [AW-3:0] dc);
        cmd(2'b00, {sub, dc});
        if (sub == 2'b01) send_word(16'h0);
        cs_end();
        if (sub == 2'b11) wen_m = 1;
        if (sub == 2'b00) wen_m = 0;
        if (sub == 2'b10 && wen_m) for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
    endtask

    task automatic fill_all(input logic [DW-1:0] d);
        cmd(2'b00, {2'b01, {(AW-2){1'b0}}}); send_word(d); cs_end();
        if (wen_m) for (int i = 0; i < DEPTH; i++) mdl[i] = d;
    endtask

    // Monitor: compare produced read words against the scoreboard
    initial begin
        forever begin
            wait (got_q.size() > 0);
            begin
                logic [DW-1:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
        wen_m = 0;
        tick(3);
        check(dout == 1'b0, "R10 reset dout", DW'(dout), '0);
        rst_n = 1'b1;
        tick(2);

        rd(6'd0, "R10 erased after reset");
        rd(6'd63, "R10 erased after reset");
        wr(6'd5, 16'h1111);                 // latch clear after reset
        rd(6'd5, "R7 locked write");

        ext(2'b11, 4'b0000);                // R5 unlock
        wr(6'd5, 16'hA5C3);
        rd(6'd5, "R3 write");
        wr(6'd63, 16'h1234);
        rd(6'd63, "R3 write top");
        erase(6'd5);
        rd(6'd5, "R4 erase");
        rd(6'd63, "R4 erase other word");

        fill_all(16'h0F0F);
        rd(6'd0, "R6 fill all");
        rd(6'd33, "R6 fill all");
        ext(2'b10, 4'b1010);
        rd(6'd10, "R6 clear all");
        fill_all(16'h5555);

        ext(2'b00, 4'b1111);                // R5 lock with other bits set
        wr(6'd7, 16'hBEEF);
        erase(6'd8);
        ext(2'b10, 4'b0000);
        rd(6'd7, "R7 locked write");
        rd(6'd8, "R7 locked erase/clear");
        fill_all(16'h0000);
        rd(6'd9, "R7 locked fill");

        ext(2'b11, 4'b0101);                // R5 unlock, don't-care bits mixed
        wr(6'd9, 16'hC001);
        rd(6'd9, "R5 unlock dont-care");

        // R8: abort mid-write
        cmd(2'b01, 6'd9);
        for (int i = 0; i < 8; i++) bit_out(1'b0);
        sk = 1'b0; tick(1); cs = 1'b0; tick(3);
        rd(6'd9, "R8 aborted write");

        // R8: abort mid-read, then dout quiet
        cmd(2'b10, 6'd9);
        bit_out(1'b0);
        check(dout == 1'b1, "R2 first bit", DW'(dout), 16'h1);
        sk = 1'b0; tick(1); cs = 1'b0; tick(1);
        check(dout == 1'b0, "R8 read abort", DW'(dout), '0);
        tick(2);

        // R1: leading zeros before the start bit
        cs = 1'b1;
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        check(dout == 1'b0, "R9 idle with clocks", DW'(dout), '0);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        for (int i = AW - 1; i >= 0; i--) bit_out(i[0] ? 1'b0 : 1'b1);
        send_word(16'h3C5A);
        cs_end();
        mdl[6'b010101] = 16'h3C5A;
        rd(6'b010101, "R1 start after zeros");

        tick(4);
        wait (got_q.size() == 0);
        tick(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule